// File: doc/BRIEF.md
# Slot-Requested Audio Transmit Stream

This block serves one outbound sample stream of a serial codec link. A small FIFO sits between the memory side and the link side. On the memory side, the block raises a DMA request while it has room. Each write strobe from the DMA engine places one sample into the FIFO.

On the link side, the codec states once per frame whether it wants a sample in this stream's slot. When it does and the stream's slot enable is set, the block hands out the oldest stored sample with the valid tag raised. If the codec asks while the FIFO is empty, the slot goes out empty and a sticky underrun flag is set. Software clears that flag with a one-cycle clear pulse.

The slot enable and the DMA enable are independent, so the FIFO can be pre-filled before the slot is switched on.

Top module: `audio_tx_stream`

## Requirements
- R1: After a synchronous active-low reset, the FIFO is empty and `slot_valid`, `slot_data` and `underrun` are 0. While `dma_en` is 1, `dma_req` is 1 in the first cycle after reset.
- R2: `dma_req` equals `dma_en` AND (FIFO count < DEPTH). It follows the registered count with no delay.
- R3: A `dma_wstrobe` cycle with the FIFO not full stores `dma_wdata`. A strobe while the FIFO holds DEPTH (4) words is ignored and its data is lost.
- R4: On a `frame_start` cycle with `slot_req`=1, `slot_en`=1 and a non-empty FIFO, the next cycle shows `slot_valid`=1 and `slot_data` equal to the oldest stored word. Exactly one word is removed, in first-in first-out order.
- R5: `slot_valid` and `slot_data` change only in the cycle after a `frame_start` pulse and hold in between. At most one word leaves per frame.
- R6: On a `frame_start` cycle with `slot_req`=0 or `slot_en`=0, the next cycle shows `slot_valid`=0 and `slot_data`=0. No word is removed and `underrun` is not touched.
- R7: On a `frame_start` cycle with `slot_req`=1, `slot_en`=1 and an empty FIFO, the next cycle shows `slot_valid`=0 and `slot_data`=0, and `underrun` becomes 1.
- R8: `underrun` stays 1 until a cycle with `udr_clr`=1. If a new underrun and a clear fall in the same cycle, the underrun wins.
- R9: A push and a pop in the same cycle both take effect. A push that lands in the same cycle as a request on an empty FIFO does not prevent the underrun, and the pushed word stays stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_en | input | 1 | Link-side enable for this stream's slot |
| dma_en | input | 1 | Enable for DMA requests |
| frame_start | input | 1 | One-cycle pulse per link frame |
| slot_req | input | 1 | Codec asks for a sample in this slot (sampled on frame_start) |
| dma_wdata | input | DATA_W | Sample word from the DMA engine |
| dma_wstrobe | input | 1 | Store dma_wdata this cycle |
| udr_clr | input | 1 | Write-one pulse clearing the underrun flag |
| slot_data | output | DATA_W | Sample sent in the slot (0 when not valid) |
| slot_valid | output | 1 | Valid tag for the slot |
| dma_req | output | 1 | Request for more sample data |
| underrun | output | 1 | Sticky underrun error |

## Verification
The bench fills the FIFO past full and then checks that the surplus strobes were dropped rather than overwriting older words. A design that overwrote them would send samples out of order. It issues a slot request while a push lands on an empty FIFO: a design that let the push satisfy the pop would send a valid slot and miss the underrun. It pairs an underrun with a clear in the same cycle, which catches a design that gives the clear priority. Random frames with the slot enable off or the request low confirm that no word is removed, which catches a design that pops without sending.

// File: rtl/tx_stream_pkg.sv
// Package: shared types for the transmit stream.
// Assumes: included first in compile order.
package tx_stream_pkg;
    // Decision taken for the slot at a frame boundary.
    typedef enum logic [1:0] {
        SLOT_IDLE     = 2'd0,
        SLOT_SEND     = 2'd1,
        SLOT_UNDERRUN = 2'd2
    } slot_outcome_e;
endpackage

// File: rtl/tx_sample_fifo.sv
// Module: tx_sample_fifo
// First-in first-out store of samples between the DMA side and the link side.
// Assumes: DEPTH >= 2; the caller never pops while empty; a push while full
// is dropped.
module tx_sample_fifo #(
    parameter int DATA_W = 20,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              push_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign head    = mem[rd_ptr];

    // Per-entry write: only the slot under the write pointer captures data.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (push_ok && wr_ptr == PTR_W'(i)) mem[i] <= wdata;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(push_ok) - CNT_W'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));                                        // R3
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);                               // R3
    AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);                                                // R7
    AST_PUSH_POP_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full) |=> $stable(count));                     // R9
endmodule

// File: rtl/tx_dma_req.sv
// Module: tx_dma_req
// Raises the DMA request while DMA is enabled and the FIFO has room.
// Assumes: fifo_full comes from registered occupancy.
module tx_dma_req (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_en,
    input  logic fifo_full,
    output logic dma_req
);
    // Request is a pure function of enable and room.
    always_comb dma_req = dma_en && !fifo_full;

    AST_REQ_DROPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !dma_req);                                        // R2
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dma_req);                                          // R2
endmodule

// File: rtl/tx_slot_ctrl.sv
// Module: tx_slot_ctrl
// Decides per frame whether the slot carries a sample, pops the FIFO,
// holds the slot output and keeps the sticky underrun flag.
// Assumes: frame_start is a one-cycle pulse; fifo_empty/fifo_head are
// registered FIFO state.
module tx_slot_ctrl
    import tx_stream_pkg::*;
#(
    parameter int DATA_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              slot_req,
    input  logic              slot_en,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_head,
    input  logic              udr_clr,
    output logic              pop,
    output logic [DATA_W-1:0] slot_data,
    output logic              slot_valid,
    output logic              underrun
);
    slot_outcome_e outcome;

    // Classify the current cycle's slot decision.
    always_comb begin
        outcome = SLOT_IDLE;
        if (frame_start && slot_req && slot_en)
            outcome = fifo_empty ? SLOT_UNDERRUN : SLOT_SEND;
    end

    // Pop only when a sample actually goes out.
    assign pop = (outcome == SLOT_SEND);

    // Slot output register, updated once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid <= 1'b0;
            slot_data  <= '0;
        end else if (frame_start) begin
            slot_valid <= (outcome == SLOT_SEND);
            slot_data  <= (outcome == SLOT_SEND) ? fifo_head : '0;
        end
    end

    // Sticky underrun flag; a new underrun beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                      underrun <= 1'b0;
        else if (outcome == SLOT_UNDERRUN) underrun <= 1'b1;
        else if (udr_clr)                underrun <= 1'b0;
    end

    AST_SEND_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && slot_req && slot_en && !fifo_empty)
        |=> slot_valid && slot_data == $past(fifo_head));               // R4
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(slot_valid) && $stable(slot_data));    // R5
    AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !(slot_req && slot_en))
        |=> !slot_valid && slot_data == '0);                            // R6
    AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && slot_req && slot_en && fifo_empty)
        |=> underrun && !slot_valid);                                   // R7
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !udr_clr) |=> underrun);                           // R8
endmodule

// File: rtl/audio_tx_stream.sv
// Module: audio_tx_stream (top)
// One outbound sample stream: a DMA-filled FIFO drained by codec slot
// requests, with a valid tag per slot and a sticky underrun flag.
// Assumes: frame_start is a one-cycle pulse per frame; udr_clr is a pulse.
module audio_tx_stream #(
    parameter int DATA_W = 20,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_en,
    input  logic              dma_en,
    input  logic              frame_start,
    input  logic              slot_req,
    input  logic [DATA_W-1:0] dma_wdata,
    input  logic              dma_wstrobe,
    input  logic              udr_clr,
    output logic [DATA_W-1:0] slot_data,
    output logic              slot_valid,
    output logic              dma_req,
    output logic              underrun
);
    logic              f_empty, f_full, f_pop;
    logic [DATA_W-1:0] f_head;

    tx_sample_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(dma_wstrobe), .wdata(dma_wdata),
        .pop(f_pop), .head(f_head), .empty(f_empty), .full(f_full)
    );

    tx_dma_req u_req (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .fifo_full(f_full),
        .dma_req(dma_req)
    );

    tx_slot_ctrl #(.DATA_W(DATA_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .slot_req(slot_req), .slot_en(slot_en), .fifo_empty(f_empty),
        .fifo_head(f_head), .udr_clr(udr_clr), .pop(f_pop),
        .slot_data(slot_data), .slot_valid(slot_valid), .underrun(underrun)
    );
endmodule

// File: tb/tb_audio_tx_stream.sv
`timescale 1ns/1ps
module tb_audio_tx_stream;
    localparam int DW = 20;
    localparam int DP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_en = 0, dma_en = 0, frame_start = 0, slot_req = 0;
    logic dma_wstrobe = 0, udr_clr = 0;
    logic [DW-1:0] dma_wdata = '0;
    logic [DW-1:0] slot_data;
    logic slot_valid, dma_req, underrun;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string note = "";

    logic [DW-1:0] q[$];
    logic [DW-1:0] e_data = '0;
    logic e_valid = 0, e_udr = 0;

    always #2 clk = ~clk;

    audio_tx_stream #(.DATA_W(DW), .DEPTH(DP)) dut (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .dma_en(dma_en),
        .frame_start(frame_start), .slot_req(slot_req), .dma_wdata(dma_wdata),
        .dma_wstrobe(dma_wstrobe), .udr_clr(udr_clr), .slot_data(slot_data),
        .slot_valid(slot_valid), .dma_req(dma_req), .underrun(underrun)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_req(input logic en, input int n);
        return en && (n < DP);
    endfunction

    // One cycle: drive at negedge, update model at posedge, check after it.
    task automatic step(input logic fs, input logic rq, input logic se,
                        input logic de, input logic st, input logic [DW-1:0] wd,
                        input logic cl);
        string tag;
        int n0;
        @(negedge clk);
        frame_start = fs; slot_req = rq; slot_en = se; dma_en = de;
        dma_wstrobe = st; dma_wdata = wd; udr_clr = cl;
        @(posedge clk);
        n0 = q.size();
        if (fs) begin
            if (rq && se && n0 > 0) begin
                e_valid = 1; e_data = q.pop_front();
                tag = "R4";
            end else begin
                e_valid = 0; e_data = '0;
                tag = (rq && se) ? ((st) ? "R9" : "R7") : "R6";
            end
        end else tag = "R5";
        if (st && n0 < DP) q.push_back(wd);
        if (fs && rq && se && n0 == 0) e_udr = 1;
        else if (cl) e_udr = 0;
        if (note != "") tag = note;
        #1;
        chk(tag, {31'd0, slot_valid}, {31'd0, e_valid});
        chk(tag, 32'(slot_data), 32'(e_data));
        chk((note != "") ? note : "R8", {31'd0, underrun}, {31'd0, e_udr});
        chk("R2", {31'd0, dma_req}, {31'd0, exp_req(de, q.size())});
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed = 32'h1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1; dma_en = 1;
        @(posedge clk); #1;
        // R1: reset state
        chk("R1", {31'd0, slot_valid}, 0);
        chk("R1", 32'(slot_data), 0);
        chk("R1", {31'd0, underrun}, 0);
        chk("R1", {31'd0, dma_req}, 1);

        // R7: request on empty FIFO
        note = "R7";
        step(1, 1, 1, 1, 0, '0, 0);
        // R8: clear and new underrun together -> stays set
        note = "R8";
        step(1, 1, 1, 1, 0, '0, 1);
        step(0, 0, 1, 1, 0, '0, 1);
        // R3: fill past full, surplus dropped
        note = "R3";
        for (int i = 0; i < 6; i++) step(0, 0, 1, 1, 1, DW'(20'hA0 + i), 0);
        // R4: drain in order
        note = "R4";
        for (int i = 0; i < 4; i++) begin
            step(1, 1, 1, 1, 0, '0, 0);
            step(0, 0, 1, 1, 0, '0, 0);
        end
        // R6: disabled slot with request does not pop
        step(0, 0, 1, 0, 1, 20'h55, 0);
        note = "R6";
        step(1, 1, 0, 0, 0, '0, 0);
        step(1, 0, 1, 0, 0, '0, 0);
        note = "R4";
        step(1, 1, 1, 0, 0, '0, 0);
        // R9: push on empty during request still underruns, word kept
        note = "R9";
        step(0, 0, 1, 0, 0, '0, 1);
        step(1, 1, 1, 1, 1, 20'h77, 0);
        step(1, 1, 1, 1, 0, '0, 0);
        note = "";

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 4) == 0, ($urandom % 4) != 0, ($urandom % 8) != 0,
                 ($urandom % 4) != 0, ($urandom % 3) == 0, DW'($urandom),
                 ($urandom % 16) == 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule